// File: doc/BRIEF.md
# Telecom Clock and Frame-Pulse Generator

This block derives a family of telecom timing signals from one 65.536 MHz master clock. A free-running counter marks out a 125 µs frame of exactly 8192 master cycles. From that counter the block drives five output clocks and four frame pulses, all locked to the frame boundary. Lanes 0 to 2 each produce a clock at a fixed rate and a frame pulse. Lane 3 has a clock and frame pulse whose rate can be selected. A fifth clock runs at either 2.048 MHz or 1.544 MHz.

A single 16-bit control word sets the behaviour of every output. For each clock it selects which edge falls on the frame boundary. For each frame pulse it sets the active level and whether the pulse is centred on the boundary or begins at it. The same word also selects the lane 3 rate and the rate of the fifth clock.

Software writes the control word through a small address/data port, and the new value can be read back on the next cycle. The outputs pick up the new settings only at the next frame boundary, so no output emits a runt pulse in mid-frame. Two mode inputs decide whether the fifth clock is driven at all.

Top module: `fgen_clkgen`

## Requirements
- R1: While reset is high, every clock and frame-pulse output is 0 and the control word reads back as 0x0000.
- R2: A write with `reg_addr` = 0x04 stores `reg_wdata`, and the stored value appears on `reg_rdata` from the next cycle while `reg_addr` = 0x04. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: The frame counter is 0 in the first cycle after reset. It counts through 8192 cycles and then wraps. Every output is registered, so the value seen in a cycle reflects the count of the cycle before it.
- R4: Clocks 0, 1 and 2 divide the master clock by 16, 8 and 4. Their polarity bits are bits 2, 5 and 8. With the bit at 1, the clock is high for the first half of each period counted from the boundary, so a rising edge lands on the boundary. With the bit at 0, it is low for that first half, so a falling edge lands there.
- R5: The frame pulse of lane i is one lane-clock period wide (D cycles). Its position bit is bit 3i. With the bit at 1, the pulse is active for frame counts 0 to D-1. With the bit at 0, it is active for counts 0 to D/2-1 and for counts 8192-D/2 to 8191.
- R6: The frame pulse of lane i has its polarity set by bit 3i+1: 1 gives an active-high pulse and 0 gives an active-low pulse.
- R7: The lane 3 clock and frame pulse divide the master clock by 16, 8, 4 or 2 for rate codes 0, 1, 2 and 3 in bits 13:12. The lane 3 clock polarity is bit 11 and follows the rule in R4.
- R8: Clock 4 has its polarity in bit 15 and its rate select in bit 14. With bit 14 at 0, it divides the master clock by 32. With bit 14 at 1, it is in its first half-period whenever (count × 193) mod 8192 < 4096, which gives 193 periods per frame and a phase of 0 at every boundary.
- R9: Clock 4 is held at 0 whenever both `master_mode` and `dpll_en` are low.
- R10: A control word written in mid-frame leaves the outputs unchanged for the rest of that frame. It takes effect from the first output cycle of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 65.536 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control port |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (stored control word at 0x04, else 0) |
| master_mode | input | 1 | High in master mode; enables clock 4 |
| dpll_en | input | 1 | Loop-enable in slave mode; also enables clock 4 |
| ck_out | output | 5 | Output clocks; bit 4 is the 2.048/1.544 MHz clock |
| fp_out | output | 4 | Frame pulses of lanes 0 to 3 |

## Verification
The hardest case to reach is a full frame of the 1.544 MHz clock. Its phase only returns to zero after 8192 cycles, so a fault in the accumulator or in its realignment shows up only near the end of the frame. A second hard case is the straddling pulse, whose leading half lies at the very end of the previous frame.

The bench keeps its own count of edges since reset. It writes each control word early in a frame and then compares every output against an arithmetic model over the whole of the following frame. The rate codes and enable combinations are chosen so that every lane 3 rate, both clock 4 rates and every gating case appear.

A last write in mid-frame is checked cycle by cycle against the old settings up to the boundary, and against the new settings after it.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

    localparam int FRAME_LEN  = 8192;
    localparam int CNT_W      = $clog2(FRAME_LEN);
    localparam int HB_W       = $clog2(CNT_W);
    localparam int N_LANES    = 4;
    localparam int LANE0_HB   = 3;     // half-period bit of the divide-by-16 lane
    localparam int T1_ALT_HB  = 4;     // half-period bit of the divide-by-32 clock
    localparam int T1_STEP    = 193;   // 1.544 MHz periods per frame
    localparam int CTRL_W     = 16;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [HB_W-1:0]  hb_t;

    typedef struct packed {
        logic ck_pol;    // 1: rising edge on boundary
        logic fp_pol;    // 1: active-high pulse
        logic fp_start;  // 1: pulse begins at boundary, 0: straddles it
    } lane_cfg_t;

    typedef struct packed {
        logic                      t1_pol;
        logic                      t1_sel;     // 1: 1.544 MHz
        logic [1:0]                fast_rate;  // lane 3 divider code
        lane_cfg_t [N_LANES-1:0]   lane;
    } ctrl_t;

    // Counter bit whose value is the half-period phase of a lane clock.
    function automatic hb_t lane_hbit(input int idx, input logic [1:0] rate);
        if (idx == N_LANES - 1)
            return hb_t'(LANE0_HB - int'(rate));
        return hb_t'(LANE0_HB - idx);
    endfunction

endpackage

// File: rtl/fgen_timebase.sv
module fgen_timebase
    import fgen_pkg::*;
#(
    parameter int STEP = T1_STEP
) (
    input  logic clk,
    input  logic rst,
    output cnt_t cnt,
    output logic at_last,
    output logic t1_phase_hi
);

    localparam cnt_t STEP_C = cnt_t'(STEP);
    localparam cnt_t LAST_C = cnt_t'(FRAME_LEN - 1);

    cnt_t acc;

    assign at_last     = (cnt == LAST_C);
    assign t1_phase_hi = acc[CNT_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            acc <= '0;
        end else if (at_last) begin
            cnt <= '0;
            acc <= '0;
        end else begin
            cnt <= cnt + cnt_t'(1);
            acc <= acc + STEP_C;
        end
    end

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        at_last |=> (cnt == '0));

    p_count_r3: assert property (@(posedge clk) disable iff (rst)
        !at_last |=> (cnt == $past(cnt) + cnt_t'(1)));

    p_realign_r8: assert property (@(posedge clk) disable iff (rst)
        at_last |=> (acc == '0));

endmodule

// File: rtl/fgen_lane.sv
module fgen_lane
    import fgen_pkg::*;
(
    input  cnt_t      cnt,
    input  hb_t       hb,
    input  lane_cfg_t cfg,
    output logic      ck,
    output logic      fp
);

    cnt_t half;
    cnt_t width;
    logic active;

    always_comb begin
        half  = cnt_t'(1) << hb;
        width = half << 1;
        ck    = cnt[hb] ^ cfg.ck_pol;
        if (cfg.fp_start)
            active = (cnt < width);
        else
            active = (cnt < half) || (cnt >= (cnt_t'(0) - half));
        fp = cfg.fp_pol ? active : ~active;
    end

endmodule

// File: rtl/fgen_t1clk.sv
module fgen_t1clk (
    input  logic div_bit,
    input  logic acc_hi,
    input  logic sel,
    input  logic pol,
    output logic ck
);

    logic first_half;

    always_comb begin
        first_half = sel ? ~acc_hi : ~div_bit;
        ck         = pol ? first_half : ~first_half;
    end

endmodule

// File: rtl/fgen_clkgen.sv
module fgen_clkgen
    import fgen_pkg::*;
#(
    parameter int              AW        = 8,
    parameter logic [AW-1:0]   CTRL_ADDR = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              master_mode,
    input  logic              dpll_en,
    output logic [N_LANES:0]  ck_out,
    output logic [N_LANES-1:0] fp_out
);

    cnt_t  cnt;
    logic  at_last;
    logic  t1_hi;
    logic  t1_ck;
    logic  t1_en;
    ctrl_t shadow_q;
    ctrl_t active_q;
    logic [N_LANES-1:0] lane_ck;
    logic [N_LANES-1:0] lane_fp;
    logic  sel_ctrl;

    assign sel_ctrl = (reg_addr == CTRL_ADDR);
    assign t1_en    = master_mode | dpll_en;

    fgen_timebase #(.STEP(T1_STEP)) u_base (
        .clk         (clk),
        .rst         (rst),
        .cnt         (cnt),
        .at_last     (at_last),
        .t1_phase_hi (t1_hi)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        fgen_lane u_lane (
            .cnt (cnt),
            .hb  (lane_hbit(g, active_q.fast_rate)),
            .cfg (active_q.lane[g]),
            .ck  (lane_ck[g]),
            .fp  (lane_fp[g])
        );
    end

    fgen_t1clk u_t1 (
        .div_bit (cnt[T1_ALT_HB]),
        .acc_hi  (t1_hi),
        .sel     (active_q.t1_sel),
        .pol     (active_q.t1_pol),
        .ck      (t1_ck)
    );

    always_ff @(posedge clk) begin
        if (rst)
            shadow_q <= '0;
        else if (reg_wr && sel_ctrl)
            shadow_q <= ctrl_t'(reg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (at_last)
            active_q <= shadow_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_out <= '0;
            fp_out <= '0;
        end else begin
            ck_out <= {t1_ck & t1_en, lane_ck};
            fp_out <= lane_fp;
        end
    end

    assign reg_rdata = sel_ctrl ? CTRL_W'(shadow_q) : '0;

    p_store_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel_ctrl) |=> (CTRL_W'(shadow_q) == $past(reg_wdata)));

    p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && sel_ctrl) |=> $stable(shadow_q));

    p_defer_r10: assert property (@(posedge clk) disable iff (rst)
        !at_last |=> $stable(active_q));

    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && !dpll_en) |=> !ck_out[N_LANES]);

endmodule

// File: tb/sim_fgen_clkgen.sv
`timescale 1ns/1ps
module sim_fgen_clkgen;

    localparam int FL = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h04;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        master_mode = 1'b1;
    logic        dpll_en = 1'b0;
    logic [4:0]  ck_out;
    logic [3:0]  fp_out;

    int n_run  = 0;
    int n_fail = 0;
    int edges  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) edges <= rst ? 0 : edges + 1;

    fgen_clkgen u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .master_mode(master_mode), .dpll_en(dpll_en),
        .ck_out(ck_out), .fp_out(fp_out)
    );

    // {control word, master_mode, dpll_en}
    localparam logic [17:0] VEC [5] = '{
        {16'h0000, 1'b1, 1'b0},
        {16'hFFFF, 1'b1, 1'b0},
        {16'h5A5A, 1'b0, 1'b1},
        {16'h2DB6, 1'b0, 1'b0},
        {16'hB249, 1'b1, 1'b1}
    };

    function automatic int obs_now();
        return (edges - 1) % FL;
    endfunction

    function automatic logic [8:0] model(logic [15:0] cfg, logic m, logic d, int c);
        logic [4:0] ck;
        logic [3:0] fp;
        logic       f4;
        for (int i = 0; i < 4; i++) begin
            int   dv;
            logic first;
            logic act;
            dv    = (i < 3) ? (16 >> i) : (16 >> cfg[13:12]);
            first = (c % dv) < (dv / 2);
            ck[i] = cfg[3*i+2] ? first : !first;
            if (cfg[3*i])
                act = (c < dv);
            else
                act = (c < dv / 2) || (c >= FL - dv / 2);
            fp[i] = cfg[3*i+1] ? act : !act;
        end
        f4    = cfg[14] ? (((c * 193) % FL) < 4096) : ((c % 32) < 16);
        ck[4] = (m || d) ? (cfg[15] ? f4 : !f4) : 1'b0;
        return {ck, fp};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_obs(int target);
        do @(negedge clk); while (obs_now() != target);
    endtask

    task automatic write_reg(logic [7:0] a, logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h04;
    endtask

    // Compare outputs for counts lo..FL-1 of the current frame.
    task automatic scan(logic [15:0] cfg, logic m, logic d, int lo, string tag);
        int bad_fix = 0, bad_fp = 0, bad_l3 = 0, bad_t1 = 0;
        for (int k = lo; k < FL; k++) begin
            logic [8:0] e;
            logic [8:0] g;
            @(negedge clk);
            e = model(cfg, m, d, k);
            g = {ck_out, fp_out};
            if (g[6:4] !== e[6:4]) bad_fix++;
            if (g[3:0] !== e[3:0]) bad_fp++;
            if (g[7]   !== e[7])   bad_l3++;
            if (g[8]   !== e[8])   bad_t1++;
            if (g !== e && bad_fix + bad_fp + bad_l3 + bad_t1 == 1)
                $display("  first mismatch %s count=%0d got=%b want=%b", tag, k, g, e);
        end
        check({tag, " R4 fixed clocks mismatches"}, 16'(bad_fix), 16'd0);
        check({tag, " R5 R6 frame pulses mismatches"}, 16'(bad_fp), 16'd0);
        check({tag, " R7 lane3 clock mismatches"}, 16'(bad_l3), 16'd0);
        check({tag, " R8 R9 clock4 mismatches"}, 16'(bad_t1), 16'd0);
    endtask

    initial begin
        #(5.0 * 195000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 clocks in reset", 16'(ck_out), 16'h0000);
        check("R1 pulses in reset", 16'(fp_out), 16'h0000);
        check("R1 control readback in reset", reg_rdata, 16'h0000);
        rst = 1'b0;

        // R2: address decode and readback
        wait_obs(5);
        write_reg(8'h08, 16'hFFFF);
        reg_addr = 8'h08; #0.1;
        check("R2 other address reads zero", reg_rdata, 16'h0000);
        reg_addr = 8'h04; #0.1;
        check("R2 other address write ignored", reg_rdata, 16'h0000);
        write_reg(8'h04, 16'h1234);
        check("R2 readback after write", reg_rdata, 16'h1234);

        // R3..R9: full-frame comparison for each vector
        for (int v = 0; v < 5; v++) begin
            logic [15:0] cfg;
            cfg         = VEC[v][17:2];
            master_mode = VEC[v][1];
            dpll_en     = VEC[v][0];
            wait_obs(10);
            write_reg(8'h04, cfg);
            wait_obs(FL - 1);
            scan(cfg, VEC[v][1], VEC[v][0], 0, $sformatf("vec%0d", v));
        end

        // R10: mid-frame write stays deferred until the boundary
        wait_obs(20);
        write_reg(8'h04, 16'h6C93);
        check("R10 new word readable at once", reg_rdata, 16'h6C93);
        scan(16'hB249, 1'b1, 1'b1, obs_now() + 1, "R10 old frame");
        scan(16'h6C93, 1'b1, 1'b1, 0, "R10 new frame");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule